// File: doc/BRIEF.md
# Core clock divider chain

This block derives a family of related core clock enables from one chosen PLL. Each PLL is presented as a one-cycle enable strobe in the system clock domain. A select field in the configuration word picks which of those strobes feeds the chain. Four divider stages follow in cascade. The first stage divides the chosen source. Every later stage divides the output of the stage before it. The output of each stage leaves the block as its own clock tap.

Each tap is a one-cycle enable strobe, so downstream logic can run at the derived rate without a second clock domain. A single write port replaces the whole configuration word. That write also restarts every stage, so the taps begin again from a common phase. Select codes that name no PLL leave the whole chain silent.

Top module: `core_clk_divchain`

## Requirements
- R1: Bits [2:0] of the configuration word select the source. A value v in 0..3 routes `src_stb[v]` into the chain. Strobes on the other source inputs have no effect on any tap.
- R2: Select values 4 to 7 are reserved. While one of them is held, no tap strobes, whatever the source inputs do.
- R3: Stage k (k = 0..3) takes its ratio field from bits [3+6k+5 : 3+6k]. That is bits [8:3], [14:9], [20:15] and [26:21]. The divide ratio of a stage is the field value plus one.
- R4: `tap_stb[0]` pulses in the same cycle as every (d0+1)-th strobe of the selected source, where d0 is the value of the stage 0 field.
- R5: For k from 1 to 3, `tap_stb[k]` pulses in the same cycle as every (dk+1)-th pulse of `tap_stb[k-1]`. A tap never pulses unless its parent pulses in that cycle.
- R6: A stage counter advances only on a strobe from its parent. Cycles with no parent strobe leave it unchanged, so each tap counts parent strobes and not clock cycles.
- R7: A cycle with `cfg_we` high loads `cfg_wdata` and clears all four stage counters. No tap pulses in that cycle. After the write, stage 0 next pulses on the (d0+1)-th source strobe.
- R8: After reset the configuration is all zeros (source 0, every ratio 1) and all counters are clear. A strobe on `src_stb[0]` then pulses all four taps at once.
- R9: A field value of 63 divides by 64. This is the largest ratio a stage supports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 27 | New configuration: select in [2:0], stage ratio fields above it |
| src_stb | input | 4 | One enable strobe per PLL source |
| tap_stb | output | 4 | Enable strobe of each divider stage, stage 0 in bit 0 |

## Verification
The hardest condition to reach from the ports is a deep tap firing at a known moment. Tap 3 pulses only after its three parents have wrapped in step, and only if gaps in the source have not disturbed any of the counts. The stimulus therefore inserts idle cycles between source strobes. It also keeps the unselected sources busy on every cycle. It then compares the tap pulse totals over a full run with the nested quotients of the ratios. Separate directed runs cover three cases: a rewrite made while a stage is partway through its count, the maximum ratio of 64, and the reserved select codes.

// File: rtl/ccdiv_pkg.sv
package ccdiv_pkg;
   // lowest bit of the ratio field for stage k
   function automatic int field_lo(input int k, input int sel_w, input int div_w);
      return sel_w + k * div_w;
   endfunction
endpackage

// File: rtl/ccdiv_src_sel.sv
module ccdiv_src_sel #(
   parameter int N_SRC = 4,
   parameter int SEL_W = 3
) (
   input  logic [N_SRC-1:0] src_stb,
   input  logic [SEL_W-1:0] sel,
   output logic             sel_stb
);
   always_comb begin
      sel_stb = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (sel == SEL_W'(i)) sel_stb = src_stb[i];
      end
   end
endmodule

// File: rtl/ccdiv_stage.sv
module ccdiv_stage #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             in_stb,
   input  logic [DIV_W-1:0] ratio_m1,
   output logic             out_stb,
   output logic [DIV_W-1:0] cnt_q
);
   logic hit;

   assign hit     = in_stb && (cnt_q == ratio_m1);
   assign out_stb = hit && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr)     cnt_q <= '0;
      else if (in_stb)  cnt_q <= hit ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/core_clk_divchain.sv
module core_clk_divchain #(
   parameter int N_SRC   = 4,
   parameter int SEL_W   = 3,
   parameter int DIV_W   = 6,
   parameter int N_STAGE = 4,
   parameter logic [SEL_W+N_STAGE*DIV_W-1:0] RESET_CFG = '0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic [SEL_W+N_STAGE*DIV_W-1:0]  cfg_wdata,
   input  logic [N_SRC-1:0]                src_stb,
   output logic [N_STAGE-1:0]              tap_stb
);
   import ccdiv_pkg::*;

   localparam int CFG_W = SEL_W + N_STAGE * DIV_W;
   localparam int CNT_W = N_STAGE * DIV_W;

   if (N_SRC < 1 || N_SRC > (1 << SEL_W)) begin : g_bad_src
      $error("N_SRC must fit in the select field");
   end
   if (DIV_W < 1 || N_STAGE < 1) begin : g_bad_stage
      $error("DIV_W and N_STAGE must be at least 1");
   end

   logic [CFG_W-1:0]   cfg_q;
   logic [SEL_W-1:0]   cfg_sel;
   logic [CNT_W-1:0]   div_flat;
   logic [CNT_W-1:0]   cnt_flat;
   logic [N_STAGE:0]   chain;

   always_ff @(posedge clk) begin
      if (!rst_n)      cfg_q <= RESET_CFG;
      else if (cfg_we) cfg_q <= cfg_wdata;
   end

   assign cfg_sel  = cfg_q[SEL_W-1:0];
   assign div_flat = cfg_q[CFG_W-1:SEL_W];

   ccdiv_src_sel #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_sel (
      .src_stb (src_stb),
      .sel     (cfg_sel),
      .sel_stb (chain[0])
   );

   for (genvar k = 0; k < N_STAGE; k++) begin : g_stage
      localparam int LO = field_lo(k, SEL_W, DIV_W);
      ccdiv_stage #(.DIV_W(DIV_W)) u_stage (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (cfg_we),
         .in_stb   (chain[k]),
         .ratio_m1 (cfg_q[LO+DIV_W-1:LO]),
         .out_stb  (chain[k+1]),
         .cnt_q    (cnt_flat[k*DIV_W +: DIV_W])
      );
   end

   assign tap_stb = chain[N_STAGE:1];
endmodule

// File: rtl/ccdiv_checks.sv
module ccdiv_checks #(
   parameter int N_SRC   = 4,
   parameter int SEL_W   = 3,
   parameter int DIV_W   = 6,
   parameter int N_STAGE = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cfg_we,
   input logic [SEL_W-1:0]         sel,
   input logic [N_STAGE*DIV_W-1:0] div_flat,
   input logic [N_STAGE*DIV_W-1:0] cnt_flat,
   input logic                     sel_stb,
   input logic [N_SRC-1:0]         src_stb,
   input logic [N_STAGE-1:0]       tap_stb
);
   p_reserved_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel) >= N_SRC) |-> (tap_stb == '0));

   p_tap0_needs_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tap_stb[0] |-> (|src_stb));

   p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |-> (tap_stb == '0));

   p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cnt_flat == '0));

   for (genvar k = 0; k < N_STAGE; k++) begin : g_chk
      logic parent;
      if (k == 0) begin : g_p0
         assign parent = sel_stb;
      end else begin : g_pk
         assign parent = tap_stb[k-1];
         p_child_needs_parent_r5: assert property (@(posedge clk) disable iff (!rst_n)
            tap_stb[k] |-> tap_stb[k-1]);
      end

      p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_flat[k*DIV_W +: DIV_W] <= div_flat[k*DIV_W +: DIV_W]);

      p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_we && !parent) |=> $stable(cnt_flat[k*DIV_W +: DIV_W]));
   end
endmodule

bind core_clk_divchain ccdiv_checks #(
   .N_SRC(N_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W), .N_STAGE(N_STAGE)
) u_checks (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .sel      (cfg_sel),
   .div_flat (div_flat),
   .cnt_flat (cnt_flat),
   .sel_stb  (chain[0]),
   .src_stb  (src_stb),
   .tap_stb  (tap_stb)
);

// File: tb/core_clk_divchain_test.sv
module core_clk_divchain_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [26:0] cfg_wdata = '0;
   logic [3:0]  src_stb = '0;
   logic [3:0]  tap_stb;
   logic [3:0]  last_tap;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 0;

   always #4 clk = ~clk;

   core_clk_divchain uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .src_stb(src_stb), .tap_stb(tap_stb)
   );

   // sel, d0, d1, d2, d3, strobes, gap, expected pulses of tap0..tap3
   localparam int VEC [8][11] = '{
      '{0,  0, 0, 0, 0,  10, 0,  10, 10, 10, 10},
      '{1,  1, 2, 0, 1,  60, 1,  30, 10, 10,  5},
      '{2,  2, 1, 1, 1,  48, 0,  16,  8,  4,  2},
      '{3,  4, 0, 3, 0,  40, 2,   8,  8,  2,  2},
      '{5,  0, 0, 0, 0,  20, 0,   0,  0,  0,  0},
      '{7,  0, 0, 0, 0,  20, 1,   0,  0,  0,  0},
      '{0, 63, 1, 0, 0, 128, 0,   2,  1,  1,  1},
      '{2,  0, 3, 2, 1,  72, 1,  72, 18,  6,  3}
   };

   function automatic logic [26:0] mk(int sel, int d0, int d1, int d2, int d3);
      return (27'(sel) & 27'h7) | (27'(d0) << 3) | (27'(d1) << 9) |
             (27'(d2) << 15) | (27'(d3) << 21);
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(logic we, logic [26:0] wd, logic [3:0] s);
      @(negedge clk);
      cfg_we = we; cfg_wdata = wd; src_stb = s;
      #2;
      last_tap = tap_stb;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8 reset state: source 0, all ratios 1
      step(0, '0, 4'h0);
      check("R8 idle taps", int'(last_tap), 0);
      step(0, '0, 4'h1);
      check("R8 all taps on src0", int'(last_tap), 15);
      // R1 unselected source ignored
      step(0, '0, 4'hE);
      check("R1 other sources ignored", int'(last_tap), 0);

      // table walk: R1 R2 R3 R4 R5 R6 R9
      for (int v = 0; v < 8; v++) begin
         int cnt[4];
         logic [3:0] others;
         logic [3:0] sel_bit;
         cnt = '{0, 0, 0, 0};
         sel_bit = (VEC[v][0] < 4) ? 4'(1 << VEC[v][0]) : 4'h0;
         others  = 4'hF & ~sel_bit;
         step(1, mk(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]), 4'hF);
         check($sformatf("R7 quiet during write v%0d", v), int'(last_tap), 0);
         for (int i = 0; i < VEC[v][5]; i++) begin
            step(0, '0, 4'hF);
            for (int t = 0; t < 4; t++) cnt[t] += int'(last_tap[t]);
            for (int g = 0; g < VEC[v][6]; g++) begin
               step(0, '0, others);
               for (int t = 0; t < 4; t++) cnt[t] += int'(last_tap[t]);
            end
         end
         for (int t = 0; t < 4; t++)
            check($sformatf("R3 R5 v%0d tap%0d pulses", v, t), cnt[t], VEC[v][7+t]);
      end

      // R4 exact cycle: ratio 3 on source 0, with an idle gap (R6)
      step(1, mk(0, 2, 0, 0, 0), 4'h0);
      step(0, '0, 4'h1);
      check("R4 first strobe", int'(last_tap), 0);
      step(0, '0, 4'h1);
      check("R4 second strobe", int'(last_tap), 0);
      step(0, '0, 4'h0);
      check("R6 idle cycle", int'(last_tap), 0);
      step(0, '0, 4'h1);
      check("R4 third strobe fires", int'(last_tap), 15);

      // R7 rewrite mid-count restarts the stage
      step(1, mk(0, 3, 0, 0, 0), 4'h0);
      step(0, '0, 4'h1);
      step(0, '0, 4'h1);
      step(1, mk(0, 3, 0, 0, 0), 4'h1);
      check("R7 quiet on rewrite", int'(last_tap), 0);
      for (int i = 0; i < 3; i++) begin
         step(0, '0, 4'h1);
         check("R7 no early tap after rewrite", int'(last_tap), 0);
      end
      step(0, '0, 4'h1);
      check("R7 tap on fourth strobe", int'(last_tap), 15);

      // R9 maximum ratio on source 1
      step(1, mk(1, 63, 0, 0, 0), 4'h0);
      begin
         int early = 0;
         for (int i = 0; i < 63; i++) begin
            step(0, '0, 4'h2);
            early += int'(last_tap[0]);
         end
         check("R9 silent for 63 strobes", early, 0);
      end
      step(0, '0, 4'h2);
      check("R9 tap on 64th strobe", int'(last_tap), 15);

      // R2 reserved select with every source busy
      step(1, mk(4, 0, 0, 0, 0), 4'h0);
      step(0, '0, 4'hF);
      check("R2 reserved select silent", int'(last_tap), 0);

      done = 1;
      summary();
      $finish;
   end
endmodule